// File: doc/BRIEF.md
# Receive Buffer Writer with Completion

This block takes the words of one accepted receive packet and writes them into a buffer whose start address and length are given when the packet begins. A start strobe latches the buffer geometry. After that, every valid input word is written one step later than it arrives. Because of this delay, the block already knows whether the next word carries the end-of-packet attention flag before it decides what to do with the word it is holding. The word that carries the flag is the hardware status word and is never written to the buffer.

When a packet ends, the block issues a one-cycle completion pulse. With the pulse it reports the number of useful words, with the trailing CRC word left out, and a 16-bit completion word. The upper byte of the completion word is the completion code. The lower byte is the status byte from the hardware, or zero if the buffer overflowed. The block then goes idle and ignores input words until the next start strobe. A packet that starts at an exact-fit boundary ends normally, and this is told apart from an overflow by the one word of look-ahead that the delayed store provides.

Top module: `rxbuf_writer`

## Requirements
- R1: During and straight after reset, `wr_en` and `done_pulse` are 0, and `words_used` and `done_status` are 0.
- R2: Before the first `start`, and again after each completion, valid input words cause no write and no completion until the next `start`.
- R3: After `start`, the k-th valid data word (k from 1) is written in the cycle in which the next valid word arrives. The write uses `wr_data` equal to that k-th word and `wr_addr` equal to `buf_base + k - 1`. The address is modulo 2^AW. The `start` cycle itself takes no word.
- R4: Suppose a word flagged by `in_eop` arrives while the buffer still has room for the held word. Then the held word, which is the CRC, is written. One cycle later, `done_pulse` is 1 and `words_used` equals the number of words written minus one. `done_status` equals 0x0100 ORed with bits [7:0] of the flagged word.
- R5: Suppose the buffer is exactly full and the next word is flagged. Then the held CRC word is not written, `words_used` equals the buffer length, and `done_status` equals 0x0100 ORed with the status byte. With a length of 0, a single data word followed by a flagged word gives `words_used` 0.
- R6: Suppose the buffer is full and the next word is not flagged. Then that word is not written. One cycle later, `done_pulse` is 1, `words_used` equals the buffer length and `done_status` is 0x0200.
- R7: If the first word after `start` is flagged, nothing is written. `words_used` becomes 0 and `done_status` becomes 0x0100 ORed with its low byte.
- R8: `done_pulse` lasts exactly one cycle. `words_used` and `done_status` hold their values until the next completion.
- R9: A `start` while a packet is in progress discards the held word, gives no completion and begins a new packet with the new base and length.
- R10: A cycle with `in_valid` low causes no write and does not advance the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start-of-packet strobe; latches buffer base and length |
| buf_base | input | AW | First buffer address, sampled with `start` |
| buf_len | input | LW | Buffer length in words, sampled with `start` |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | DW | Input word |
| in_eop | input | 1 | Marks the present word as end-of-packet status |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Buffer write address |
| wr_data | output | DW | Buffer write data |
| words_used | output | LW | Reported packet length of the last completion |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_status | output | 16 | Completion code in [15:8], hardware status in [7:0] |

## Verification
The two functions that can fall in the same cycle are the delayed store of the CRC word and the recognition of end of packet. In a normal ending both act on the one clock edge that sees the flagged word. The bench provokes this at several distances from the buffer limit: the CRC landing well inside the buffer, the CRC landing in the last free slot, and the CRC arriving when no slot is left. The cycle-level model then judges each case by whether a write occurs in that cycle, which address it takes, and whether the reported length and code distinguish a normal ending from an exact fit or an overflow.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EMPTY = 2'd1,
    ST_HOLD  = 2'd2
  } rxw_state_t;

  localparam logic [15:0] CC_DONE    = 16'h0100;
  localparam logic [15:0] CC_BUF_OVF = 16'h0200;

  // completion word for a clean ending: code in the upper byte, hw status below
  function automatic logic [15:0] merge_done(input logic [7:0] hw);
    return CC_DONE | {8'h00, hw};
  endfunction

endpackage

// File: rtl/rxw_space.sv
module rxw_space #(
  parameter int AW = 12,
  parameter int LW = 8,
  localparam int CW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic          full,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic [LW-1:0] len_q
);

  logic [AW-1:0] end_q;

  // address of the next free slot: buffer end plus negative remaining count
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] e,
                                               input logic [CW-1:0] c);
    return e + AW'($signed(c));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      end_q <= '0;
      len_q <= '0;
    end else if (load) begin
      cnt   <= '0 - {1'b0, len};
      end_q <= base + AW'(len);
      len_q <= len;
    end else if (step) begin
      cnt   <= cnt + 1'b1;
    end
  end

  assign full = (cnt == '0);
  assign addr = slot_addr(end_q, cnt);

endmodule

// File: rtl/rxw_hold.sv
module rxw_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
  import rxw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  input  logic       in_eop,
  input  logic       full,
  output rxw_state_t state,
  output logic       ev_first,
  output logic       ev_store,
  output logic       ev_hold_load,
  output logic       ev_zero_len,
  output logic       ev_end_normal,
  output logic       ev_end_exact,
  output logic       ev_overflow,
  output logic       ev_finish
);

  rxw_state_t state_nx;
  logic       take;

  assign take          = in_valid && !start;
  assign ev_zero_len   = (state == ST_EMPTY) && take && in_eop;
  assign ev_first      = (state == ST_EMPTY) && take && !in_eop;
  assign ev_store      = (state == ST_HOLD) && take && !full;
  assign ev_end_normal = ev_store && in_eop;
  assign ev_end_exact  = (state == ST_HOLD) && take && full && in_eop;
  assign ev_overflow   = (state == ST_HOLD) && take && full && !in_eop;
  assign ev_hold_load  = ev_first || (ev_store && !in_eop);
  assign ev_finish     = ev_zero_len || ev_end_normal || ev_end_exact || ev_overflow;

  always_comb begin
    state_nx = state;
    if (start)          state_nx = ST_EMPTY;
    else if (ev_finish) state_nx = ST_IDLE;
    else if (ev_first)  state_nx = ST_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/rxw_completion.sv
module rxw_completion
  import rxw_pkg::*;
#(
  parameter int LW = 8,
  localparam int CW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_zero_len,
  input  logic          ev_end_normal,
  input  logic          ev_end_exact,
  input  logic          ev_overflow,
  input  logic [7:0]    hw_status,
  input  logic [LW-1:0] len_q,
  input  logic [CW-1:0] cnt,
  output logic          done_pulse,
  output logic [LW-1:0] words_used,
  output logic [15:0]   done_status
);

  // words written before this step = length + (negative remaining count);
  // the word stored on this step is the CRC and is not counted
  function automatic logic [LW-1:0] used_normal(input logic [LW-1:0] l,
                                                input logic [CW-1:0] c);
    return LW'({1'b0, l} + c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse  <= 1'b0;
      words_used  <= '0;
      done_status <= '0;
    end else begin
      done_pulse <= ev_zero_len || ev_end_normal || ev_end_exact || ev_overflow;
      if (ev_zero_len) begin
        words_used  <= '0;
        done_status <= merge_done(hw_status);
      end else if (ev_end_normal) begin
        words_used  <= used_normal(len_q, cnt);
        done_status <= merge_done(hw_status);
      end else if (ev_end_exact) begin
        words_used  <= len_q;
        done_status <= merge_done(hw_status);
      end else if (ev_overflow) begin
        words_used  <= len_q;
        done_status <= CC_BUF_OVF;
      end
    end
  end

endmodule

// File: rtl/rxbuf_writer.sv
module rxbuf_writer
  import rxw_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] buf_base,
  input  logic [LW-1:0] buf_len,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_eop,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [LW-1:0] words_used,
  output logic          done_pulse,
  output logic [15:0]   done_status
);

  localparam int CW = LW + 1;

  rxw_state_t    state;
  logic          full;
  logic [CW-1:0] cnt;
  logic [LW-1:0] len_q;
  logic          ev_first, ev_store, ev_hold_load, ev_zero_len;
  logic          ev_end_normal, ev_end_exact, ev_overflow, ev_finish;
  logic          st_idle;

  rxw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_eop(in_eop), .full(full), .state(state),
    .ev_first(ev_first), .ev_store(ev_store), .ev_hold_load(ev_hold_load),
    .ev_zero_len(ev_zero_len), .ev_end_normal(ev_end_normal),
    .ev_end_exact(ev_end_exact), .ev_overflow(ev_overflow),
    .ev_finish(ev_finish)
  );

  rxw_space #(.AW(AW), .LW(LW)) u_space (
    .clk(clk), .rst_n(rst_n), .load(start), .base(buf_base), .len(buf_len),
    .step(ev_store), .full(full), .addr(wr_addr), .cnt(cnt), .len_q(len_q)
  );

  rxw_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(ev_hold_load), .d(in_data), .q(wr_data)
  );

  rxw_completion #(.LW(LW)) u_done (
    .clk(clk), .rst_n(rst_n), .ev_zero_len(ev_zero_len),
    .ev_end_normal(ev_end_normal), .ev_end_exact(ev_end_exact),
    .ev_overflow(ev_overflow), .hw_status(in_data[7:0]), .len_q(len_q),
    .cnt(cnt), .done_pulse(done_pulse), .words_used(words_used),
    .done_status(done_status)
  );

  assign wr_en   = ev_store;
  assign st_idle = (state == ST_IDLE) && !ev_finish;

endmodule

// File: rtl/rxbuf_writer_chk.sv
module rxbuf_writer_chk #(
  parameter int AW = 12,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_valid,
  input logic [7:0]    hw_byte,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [LW-1:0] words_used,
  input logic          done_pulse,
  input logic [15:0]   done_status,
  input logic [LW-1:0] len_q,
  input logic          st_idle,
  input logic          ev_zero_len,
  input logic          ev_end_normal,
  input logic          ev_end_exact,
  input logic          ev_overflow
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !wr_en);

  assert_write_needs_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (in_valid && !start));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!wr_en || wr_addr == $past(wr_addr) + 1'b1));

  assert_normal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end_normal |=> (done_pulse && done_status == {8'h01, $past(hw_byte)}));

  assert_exact_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end_exact |-> !wr_en);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (done_pulse && done_status == 16'h0200 && words_used == $past(len_q)));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero_len |=> (done_pulse && words_used == '0));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done_pulse && !wr_en));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !wr_en);

endmodule

bind rxbuf_writer rxbuf_writer_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .hw_byte(in_data[7:0]), .wr_en(wr_en), .wr_addr(wr_addr),
  .words_used(words_used), .done_pulse(done_pulse), .done_status(done_status),
  .len_q(len_q), .st_idle(st_idle), .ev_zero_len(ev_zero_len),
  .ev_end_normal(ev_end_normal), .ev_end_exact(ev_end_exact),
  .ev_overflow(ev_overflow)
);

// File: tb/rxbuf_writer_test.sv
`timescale 1ns/1ps
module rxbuf_writer_test;

  localparam int DW = 16, AW = 12, LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] buf_base = '0;
  logic [LW-1:0] buf_len = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_eop = 1'b0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [LW-1:0] words_used;
  logic          done_pulse;
  logic [15:0]   done_status;

  rxbuf_writer #(.DW(DW), .AW(AW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_base(buf_base),
    .buf_len(buf_len), .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .words_used(words_used), .done_pulse(done_pulse), .done_status(done_status)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // behavioural model: 0 idle, 1 waiting for first word, 2 holding a word
  int          m_phase = 0;
  int          m_rem = 0;
  int          m_len = 0;
  int          m_base = 0;
  int          m_written = 0;
  logic [15:0] m_held = '0;
  bit          x_done = 1'b0;
  int          x_used = 0;
  logic [15:0] x_status = '0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic finish_pkt(input int used, input logic [15:0] st);
    x_done   = 1'b1;
    x_used   = used;
    x_status = st;
    m_phase  = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
      chk(done_pulse == 1'b0, "R1 done_pulse in reset", done_pulse, 0);
      chk(words_used == '0, "R1 words_used in reset", words_used, 0);
      chk(done_status == '0, "R1 done_status in reset", done_status, 0);
      m_phase = 0; x_done = 0; x_used = 0; x_status = '0;
    end else begin
      bit exp_wr;
      chk(done_pulse == x_done, "done_pulse", done_pulse, x_done);
      chk(words_used == LW'(x_used), "words_used", words_used, x_used);
      chk(done_status == x_status, "done_status", done_status, x_status);
      exp_wr = (m_phase == 2) && in_valid && !start && (m_rem > 0);
      chk(wr_en == exp_wr, "wr_en", wr_en, exp_wr);
      if (exp_wr) begin
        chk(wr_addr == AW'(m_base + m_written), "wr_addr", wr_addr, AW'(m_base + m_written));
        chk(wr_data == m_held, "wr_data", wr_data, m_held);
      end
      x_done = 1'b0;
      if (start) begin
        m_phase = 1; m_base = buf_base; m_len = buf_len;
        m_rem = buf_len; m_written = 0;
      end else if (in_valid) begin
        if (m_phase == 1) begin
          if (in_eop) finish_pkt(0, 16'h0100 | {8'h00, in_data[7:0]});
          else begin m_held = in_data; m_phase = 2; end
        end else if (m_phase == 2) begin
          if (m_rem > 0) begin
            m_written++; m_rem--;
            if (in_eop) finish_pkt(m_written - 1, 16'h0100 | {8'h00, in_data[7:0]});
            else m_held = in_data;
          end else if (in_eop) finish_pkt(m_len, 16'h0100 | {8'h00, in_data[7:0]});
          else finish_pkt(m_len, 16'h0200);
        end
      end
    end
  end

  task automatic step(input bit s, input bit v, input logic [15:0] d, input bit e);
    @(posedge clk); #1;
    start = s; in_valid = v; in_data = d; in_eop = e;
  endtask

  task automatic begin_pkt(input int base, input int len);
    @(posedge clk); #1;
    start = 1'b1; in_valid = 1'b1; in_data = 16'hDEAD; in_eop = 1'b0;
    buf_base = AW'(base); buf_len = LW'(len);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 16'h0, 0);
  endtask

  // n data words, a CRC word, then the flagged status word
  task automatic body(input int n, input logic [7:0] hw, input bit stall, input int tag);
    for (int i = 0; i < n; i++) begin
      step(0, 1, 16'(tag * 256 + i), 0);
      if (stall && (i % 2 == 0)) idle(1);
    end
    step(0, 1, 16'hC0C0 + 16'(tag), 0);
    if (stall) idle(1);
    step(0, 1, {8'hE0, hw}, 1);
    idle(2);
  endtask

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    cur_req = "R2";
    for (int i = 0; i < 4; i++) step(0, 1, 16'h1111 * 16'(i), i == 3);
    idle(2);
    cur_req = "R3/R4";
    begin_pkt(12'h100, 8); body(4, 8'h5A, 0, 1);
    cur_req = "R3/R10";
    begin_pkt(12'h200, 10); body(5, 8'h33, 1, 2);
    cur_req = "R4 last slot";
    begin_pkt(12'h300, 5); body(4, 8'h71, 0, 3);
    cur_req = "R5";
    begin_pkt(12'h400, 4); body(4, 8'h0F, 0, 4);
    cur_req = "R5 zero length buffer";
    begin_pkt(12'h450, 0); body(0, 8'h99, 0, 5);
    cur_req = "R6/R8";
    begin_pkt(12'h500, 3);
    for (int i = 0; i < 7; i++) step(0, 1, 16'h6000 + 16'(i), 0);
    step(0, 1, 16'hE022, 1);
    idle(2);
    cur_req = "R7";
    begin_pkt(12'h600, 6);
    step(0, 1, 16'hE0A5, 1);
    idle(2);
    cur_req = "R9";
    begin_pkt(12'h700, 6);
    for (int i = 0; i < 3; i++) step(0, 1, 16'h7700 + 16'(i), 0);
    begin_pkt(12'hFFE, 6); body(3, 8'h44, 0, 9);
    cur_req = "R2 after completion";
    for (int i = 0; i < 3; i++) step(0, 1, 16'h8800 + 16'(i), i == 2);
    idle(3);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule